// File: doc/BRIEF.md
# Parallel-Port Adapter Register Access Sequencer

This block sits on the host side of a PC-style parallel port and performs one register read or one register write on an attached bus adapter. A single request names the access direction, the register group (the register file or the command set), a 3-bit register index, the write value and the transfer mode. The block then walks a fixed script of steps. Each step changes either the 8 data lines or the 6 control lines. The script is an opening byte, a framing pulse, a mode byte, a second framing pulse, the address byte and the framing pulse again, followed by a tail that depends on the operation.

Reads run in one of two modes. In nibble mode the adapter answers on the status lines over two strobes, and the result byte is rebuilt from the shifted and inverted status bits. In byte mode the port is turned around and the data lines are sampled directly. Writes place the value on the data lines and strobe it with a control pulse. Every step is held for a number of clocks set by the hold input, which is captured at request time. This lets the same block serve slow and fast adapters. Completion is signalled by a one-clock done pulse, and in the same cycle the read result is valid.

Top module: `ppa_reg_seq`

## Requirements
- R1: The address step drives data = {5'b0, reg_idx_i} + 0x20 when cmd_sel_i is 0 (register file), or + 0x40 when cmd_sel_i is 1 (command set).
- R2: Every access begins with step 0 driving data 0x81. Steps 1–4 drive control 0x05, 0x0D, 0x05, 0x04. Steps 6–9 drive control 0x05, 0x07, 0x05, 0x04. Steps 11–14 repeat control 0x05, 0x0D, 0x05, 0x04.
- R3: Step 5 drives the mode byte onto the data lines. The byte is 0x11 for a byte-mode read (byte_mode_i = 1, wr_i = 0) and 0x01 for every other access.
- R4: A nibble-mode read continues with control 0x06, 0x04, 0x06, 0x04 (steps 15–18). The status byte is sampled as A in the last cycle of step 15 and as B in the last cycle of step17. The result is {~B[7], B[5:3], ~A[7], A[5:3]} (bit 7 down to bit 0).
- R5: A byte-mode read continues with data 0x00 (step 15), control 0x26 (step 16) and control 0x04 (step 17). The result is the data-line input sampled in the last cycle of step 16.
- R6: A write continues with data = write value (step 15), then control 0x05, 0x07, 0x05, 0x04 (steps 16–19). The write path is the same in both modes.
- R7: Every step holds its line values for exactly hold_i + 1 clocks. hold_i is captured when the request is accepted, so an access lasts (number of steps) × (hold + 1) busy cycles.
- R8: A request raised while busy_o is high is ignored. The running script, its result and its single done pulse are unchanged, and no second access starts.
- R9: done_o is high for exactly one clock, in the cycle after the last busy cycle, with busy_o low. For reads, rdata_o holds the result from that cycle onward.
- R10: After reset and while idle, control is 0x04, data is 0x00, busy_o and done_o are low, and rdata_o is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start an access (accepted only when idle) |
| wr_i | input | 1 | 1 = write, 0 = read |
| cmd_sel_i | input | 1 | 0 = register file, 1 = command set |
| reg_idx_i | input | 3 | Register index |
| wdata_i | input | 8 | Write value |
| byte_mode_i | input | 1 | 0 = nibble mode, 1 = byte mode |
| hold_i | input | HOLD_W | Extra clocks each step is held |
| pd_i | input | 8 | Data lines as read back from the port |
| stat_i | input | 8 | Status lines |
| pd_o | output | 8 | Data lines driven to the port |
| pctl_o | output | 6 | Control lines driven to the port |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Read result |

## Verification
The bench recomputes the full step script for each access and compares every busy cycle against it, using hold values of 0 to 3. A wrong step-length count would shift the whole trace, and a dropped framing pulse would misalign every later step. Nibble reads use status patterns whose bit 7 and bits 5:3 differ between strobes. A design that swapped the strobes, forgot the inversion of bit 7 or used the wrong bit slice would return a wrong byte. The mode byte is exercised for byte-mode reads and writes, because a design that keyed it on mode alone would send 0x11 on a byte-mode write. A request is injected mid-access, which a design without a busy guard would turn into a restarted script or a second done pulse.

// File: rtl/ppa_seq_pkg.sv
package ppa_seq_pkg;
  localparam int STEP_W   = 5;
  localparam int CTL_W    = 6;
  localparam int STEP_LAST_WR  = 19;
  localparam int STEP_LAST_BRD = 17;
  localparam int STEP_LAST_NRD = 18;

  localparam logic [7:0]       DATA_OPEN   = 8'h81;
  localparam logic [7:0]       MODE_PLAIN  = 8'h01;
  localparam logic [7:0]       MODE_BYTERD = 8'h11;
  localparam logic [7:0]       BASE_REGF   = 8'h20;
  localparam logic [7:0]       BASE_CMDS   = 8'h40;
  localparam logic [CTL_W-1:0] CTL_IDLE    = 6'h04;
  localparam logic [CTL_W-1:0] CTL_ARM     = 6'h05;
  localparam logic [CTL_W-1:0] CTL_FRAME_A = 6'h0D;
  localparam logic [CTL_W-1:0] CTL_FRAME_B = 6'h07;
  localparam logic [CTL_W-1:0] CTL_NSTROBE = 6'h06;
  localparam logic [CTL_W-1:0] CTL_BREAD   = 6'h26;

  typedef enum logic [1:0] {SMP_NONE, SMP_A, SMP_B, SMP_D} smp_e;

  typedef struct packed {
    logic       is_ctl;
    logic [7:0] val;
    smp_e       smp;
    logic       last;
  } act_t;
endpackage

// File: rtl/ppa_hold_timer.sv
module ppa_hold_timer #(
  parameter int HOLD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [HOLD_W-1:0] val_i,
  input  logic              run_i,
  output logic              expire_o
);
  logic [HOLD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= val_i;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);

  // R7
  cnt_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/ppa_step_rom.sv
module ppa_step_rom
  import ppa_seq_pkg::*;
(
  input  logic [STEP_W-1:0] step_i,
  input  logic              wr_i,
  input  logic              byte_i,
  input  logic [7:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output act_t              act_o
);
  logic [7:0] mode_byte;
  assign mode_byte = (byte_i && !wr_i) ? MODE_BYTERD : MODE_PLAIN;

  function automatic act_t ctl(input logic [CTL_W-1:0] v);
    return '{is_ctl: 1'b1, val: {2'b00, v}, smp: SMP_NONE, last: 1'b0};
  endfunction

  function automatic act_t dat(input logic [7:0] v);
    return '{is_ctl: 1'b0, val: v, smp: SMP_NONE, last: 1'b0};
  endfunction

  always_comb begin
    act_o = ctl(CTL_IDLE);
    unique case (step_i)
      5'd0:  act_o = dat(DATA_OPEN);
      5'd1, 5'd6, 5'd8, 5'd11, 5'd13: act_o = ctl(CTL_ARM);
      5'd2, 5'd12: act_o = ctl(CTL_FRAME_A);
      5'd7:  act_o = ctl(CTL_FRAME_B);
      5'd3:  act_o = ctl(CTL_ARM);
      5'd4, 5'd9, 5'd14: act_o = ctl(CTL_IDLE);
      5'd5:  act_o = dat(mode_byte);
      5'd10: act_o = dat(addr_i);
      default: begin
        if (wr_i) begin
          unique case (step_i)
            5'd15: act_o = dat(wdata_i);
            5'd16, 5'd18: act_o = ctl(CTL_ARM);
            5'd17: act_o = ctl(CTL_FRAME_B);
            default: begin act_o = ctl(CTL_IDLE); act_o.last = 1'b1; end
          endcase
        end else if (byte_i) begin
          unique case (step_i)
            5'd15: act_o = dat(8'h00);
            5'd16: begin act_o = ctl(CTL_BREAD); act_o.smp = SMP_D; end
            default: begin act_o = ctl(CTL_IDLE); act_o.last = 1'b1; end
          endcase
        end else begin
          unique case (step_i)
            5'd15: begin act_o = ctl(CTL_NSTROBE); act_o.smp = SMP_A; end
            5'd16: act_o = ctl(CTL_IDLE);
            5'd17: begin act_o = ctl(CTL_NSTROBE); act_o.smp = SMP_B; end
            default: begin act_o = ctl(CTL_IDLE); act_o.last = 1'b1; end
          endcase
        end
      end
    endcase
  end
endmodule

// File: rtl/ppa_nibble_pack.sv
module ppa_nibble_pack (
  input  logic [3:0] lo_i,
  input  logic [3:0] hi_i,
  output logic [7:0] byte_o
);
  // inputs carry {s7, s5, s4, s3}; s7 arrives inverted on the wire
  assign byte_o = {~hi_i[3], hi_i[2:0], ~lo_i[3], lo_i[2:0]};
endmodule

// File: rtl/ppa_reg_seq.sv
module ppa_reg_seq
  import ppa_seq_pkg::*;
#(
  parameter int HOLD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic              cmd_sel_i,
  input  logic [2:0]        reg_idx_i,
  input  logic [7:0]        wdata_i,
  input  logic              byte_mode_i,
  input  logic [HOLD_W-1:0] hold_i,
  input  logic [7:0]        pd_i,
  input  logic [7:0]        stat_i,
  output logic [7:0]        pd_o,
  output logic [CTL_W-1:0]  pctl_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [7:0]        rdata_o
);
  logic              busy_q, done_q;
  logic [STEP_W-1:0] step_q;
  logic              wr_q, byte_q;
  logic [7:0]        addr_q, wdata_q;
  logic [HOLD_W-1:0] hold_q;
  logic [3:0]        a_q, b_q;
  logic [7:0]        d_q, rdata_q, pd_q, nib_byte;
  logic [CTL_W-1:0]  pctl_q;
  logic              start, expire, advance;
  act_t              act_cur, act_nxt;
  logic              unused_stat;

  assign unused_stat = ^{stat_i[6], stat_i[2:0]};
  assign start   = req_i && !busy_q;
  assign advance = busy_q && expire && !act_cur.last;

  ppa_step_rom i_rom_cur (
    .step_i(step_q), .wr_i(wr_q), .byte_i(byte_q),
    .addr_i(addr_q), .wdata_i(wdata_q), .act_o(act_cur));

  ppa_step_rom i_rom_nxt (
    .step_i(step_q + 5'd1), .wr_i(wr_q), .byte_i(byte_q),
    .addr_i(addr_q), .wdata_i(wdata_q), .act_o(act_nxt));

  ppa_hold_timer #(.HOLD_W(HOLD_W)) i_timer (
    .clk_i, .rst_ni,
    .load_i(start || advance),
    .val_i(start ? hold_i : hold_q),
    .run_i(busy_q),
    .expire_o(expire));

  ppa_nibble_pack i_pack (.lo_i(a_q), .hi_i(b_q), .byte_o(nib_byte));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      step_q  <= '0;
      wr_q    <= 1'b0;
      byte_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      hold_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q  <= 1'b1;
        step_q  <= '0;
        wr_q    <= wr_i;
        byte_q  <= byte_mode_i;
        addr_q  <= {5'b0, reg_idx_i} + (cmd_sel_i ? BASE_CMDS : BASE_REGF);
        wdata_q <= wdata_i;
        hold_q  <= hold_i;
      end else if (busy_q && expire) begin
        if (act_cur.last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + 5'd1;
        end
      end
    end
  end

  // line drivers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_q   <= '0;
      pctl_q <= CTL_IDLE;
    end else if (start) begin
      pd_q <= DATA_OPEN;
    end else if (advance) begin
      if (act_nxt.is_ctl) pctl_q <= act_nxt.val[CTL_W-1:0];
      else                pd_q   <= act_nxt.val;
    end
  end

  // sampling and result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q     <= '0;
      b_q     <= '0;
      d_q     <= '0;
      rdata_q <= '0;
    end else if (busy_q && expire) begin
      unique case (act_cur.smp)
        SMP_A:   a_q <= {stat_i[7], stat_i[5:3]};
        SMP_B:   b_q <= {stat_i[7], stat_i[5:3]};
        SMP_D:   d_q <= pd_i;
        default: ;
      endcase
      if (act_cur.last && !wr_q) rdata_q <= byte_q ? d_q : nib_byte;
    end
  end

  assign pd_o    = pd_q;
  assign pctl_o  = pctl_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R7
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !expire) |=> ($stable(pd_o) && $stable(pctl_o)));
  // R8
  busy_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i) |=> ($stable(addr_q) && $stable(wr_q) && $stable(hold_q)));
  // R10
  idle_ctl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (pctl_o == CTL_IDLE));
  // R2
  open_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (pd_o == DATA_OPEN && busy_o));
endmodule

// File: tb/test_ppa_reg_seq.sv
`timescale 1ns/1ps
module test_ppa_reg_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0, sel = 1'b0, bm = 1'b0;
  logic [2:0] idx = '0;
  logic [7:0] wd = '0, pdin = '0, sa = '0, sb = '0;
  logic [HW-1:0] hold = '0;
  logic [7:0] stat, pd;
  logic [5:0] pctl;
  logic busy, done;
  logic [7:0] rdata;
  logic st_phase = 1'b0, phase_clr = 1'b0;
  logic [5:0] prev_ctl = 6'h04;

  int checks = 0, failures = 0;
  logic [7:0] exp_pd [24];
  logic [5:0] exp_ctl [24];
  logic [7:0] obs_pd [24];
  logic [5:0] obs_ctl [24];
  int exp_n;
  logic [7:0] cur_d;
  logic [5:0] cur_c;

  always #(CLK_PERIOD/2) clk = ~clk;

  // adapter status model: A until the first 6->4 control edge, then B
  always @(posedge clk) begin
    prev_ctl <= pctl;
    if (phase_clr) st_phase <= 1'b0;
    else if (prev_ctl == 6'h06 && pctl == 6'h04) st_phase <= 1'b1;
  end
  assign stat = st_phase ? sb : sa;

  ppa_reg_seq #(.HOLD_W(HW)) i_ppa_reg_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .cmd_sel_i(sel),
    .reg_idx_i(idx), .wdata_i(wd), .byte_mode_i(bm), .hold_i(hold),
    .pd_i(pdin), .stat_i(stat), .pd_o(pd), .pctl_o(pctl),
    .busy_o(busy), .done_o(done), .rdata_o(rdata));

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, expv);
    end
  endtask

  task automatic push_d(input logic [7:0] v);
    cur_d = v; exp_pd[exp_n] = cur_d; exp_ctl[exp_n] = cur_c; exp_n++;
  endtask
  task automatic push_c(input logic [5:0] v);
    cur_c = v; exp_pd[exp_n] = cur_d; exp_ctl[exp_n] = cur_c; exp_n++;
  endtask

  function automatic logic [7:0] nib(input logic [7:0] a, input logic [7:0] b);
    return {~b[7], b[5], b[4], b[3], ~a[7], a[5], a[4], a[3]};
  endfunction

  task automatic build_exp(input logic w, input logic s, input logic [2:0] i,
                           input logic [7:0] v, input logic m);
    exp_n = 0; cur_d = pd; cur_c = 6'h04;
    push_d(8'h81); push_c(6'h05); push_c(6'h0D); push_c(6'h05); push_c(6'h04);
    push_d((m && !w) ? 8'h11 : 8'h01);
    push_c(6'h05); push_c(6'h07); push_c(6'h05); push_c(6'h04);
    push_d((s ? 8'h40 : 8'h20) + {5'b0, i});
    push_c(6'h05); push_c(6'h0D); push_c(6'h05); push_c(6'h04);
    if (w) begin
      push_d(v); push_c(6'h05); push_c(6'h07); push_c(6'h05); push_c(6'h04);
    end else if (m) begin
      push_d(8'h00); push_c(6'h26); push_c(6'h04);
    end else begin
      push_c(6'h06); push_c(6'h04); push_c(6'h06); push_c(6'h04);
    end
  endtask

  task automatic run_op(input string name, input logic w, input logic s,
                        input logic [2:0] i, input logic [7:0] v, input logic m,
                        input logic [HW-1:0] h, input logic [7:0] a,
                        input logic [7:0] b, input logic [7:0] d, input logic inject);
    int cyc = 0, dones = 0, steady_bad = 0, hp = int'(h) + 1;
    logic [7:0] got_rd = '0;
    build_exp(w, s, i, v, m);
    @(negedge clk);
    phase_clr = 1'b1; sa = a; sb = b; pdin = d;
    wr = w; sel = s; idx = i; wd = v; bm = m; hold = h; req = 1'b1;
    @(negedge clk);
    req = 1'b0; phase_clr = 1'b0;
    while (busy && cyc < 2000) begin
      if (cyc / hp < 24) begin
        if (cyc % hp == 0) begin
          obs_pd[cyc/hp] = pd; obs_ctl[cyc/hp] = pctl;
        end else if (pd !== obs_pd[cyc/hp] || pctl !== obs_ctl[cyc/hp]) steady_bad++;
      end
      if (inject && cyc == 3) begin
        req = 1'b1; wr = ~w; sel = ~s; idx = ~i; bm = ~m; hold = h + 1'b1;
      end
      if (inject && cyc == 4) req = 1'b0;
      @(negedge clk);
      cyc++;
      if (done) begin dones++; got_rd = rdata; end
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (done) dones++;
    end
    // R7: total length and per-step steadiness
    chk({name, " R7 busy cycles"}, cyc, exp_n * hp);
    chk({name, " R7 step steady"}, steady_bad, 0);
    // R2: opening byte and framing pulses
    for (int k = 0; k < 15; k++)
      if (k != 5 && k != 10)
        chk({name, " R2 step ", $sformatf("%0d", k)}, {obs_pd[k], 2'b0, obs_ctl[k]},
            {exp_pd[k], 2'b0, exp_ctl[k]});
    chk({name, " R3 mode byte"}, obs_pd[5], exp_pd[5]);
    chk({name, " R1 address byte"}, obs_pd[10], exp_pd[10]);
    for (int k = 15; k < exp_n; k++)
      chk({name, w ? " R6 tail step " : (m ? " R5 tail step " : " R4 tail step "),
           $sformatf("%0d", k)}, {obs_pd[k], 2'b0, obs_ctl[k]},
          {exp_pd[k], 2'b0, exp_ctl[k]});
    chk({name, inject ? " R8 single done" : " R9 single done"}, dones, 1);
    chk({name, " R9 idle after"}, {busy, pctl}, {1'b0, 6'h04});
    if (!w) chk({name, m ? " R5 byte result" : " R4 nibble result"}, got_rd,
                m ? d : nib(a, b));
    if (inject) chk({name, " R8 result kept"}, rdata, m ? d : nib(a, b));
  endtask

  task automatic t_reset();
    chk("R10 reset ctl", pctl, 6'h04);
    chk("R10 reset data", pd, 8'h00);
    chk("R10 reset flags", {busy, done}, 2'b00);
    chk("R10 reset rdata", rdata, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    run_op("nib_rf",   1'b0, 1'b0, 3'd5, 8'h00, 1'b0, 4'd0, 8'hA8, 8'h30, 8'h00, 1'b0);
    run_op("nib_cmd",  1'b0, 1'b1, 3'd7, 8'h00, 1'b0, 4'd3, 8'h5F, 8'hC7, 8'h00, 1'b0);
    run_op("byte_rf",  1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 4'd1, 8'h00, 8'h00, 8'hC3, 1'b0);
    run_op("byte_cmd", 1'b0, 1'b1, 3'd3, 8'h00, 1'b1, 4'd0, 8'h00, 8'h00, 8'h3C, 1'b0);
    run_op("wr_nib",   1'b1, 1'b0, 3'd2, 8'hA5, 1'b0, 4'd2, 8'h00, 8'h00, 8'h00, 1'b0);
    run_op("wr_byte",  1'b1, 1'b1, 3'd6, 8'h5A, 1'b1, 4'd0, 8'h00, 8'h00, 8'h00, 1'b0);
    run_op("busy_req", 1'b0, 1'b0, 3'd1, 8'h00, 1'b0, 4'd1, 8'h80, 8'h38, 8'h00, 1'b1);
    run_op("busy_reqb",1'b0, 1'b1, 3'd4, 8'h00, 1'b1, 4'd0, 8'h00, 8'h00, 8'h96, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule